// File: doc/BRIEF.md
# Prioritized Trap-Type Selector

This block sits between the sources of exceptions, resets and interrupts in a processor core and the logic that takes a trap. Every cycle it looks at all pending requests and selects one winner. It reports the winner's 9-bit trap-type code, its priority value and a valid flag.

Thirty fixed faults arrive as a bit vector. Each fixed fault has its own code and priority, and many of them share a priority value. Six classes carry an instance index that is added into a base code: one interrupt level, four window spill/fill classes and the software trap number.

Arbitration follows a fixed order. The lower priority value wins. When two requests have the same priority value, the lower trap-type code wins. A parameter decides whether the result leaves through a register stage or comes straight from the combinational arbiter.

Top module: `trap_type_selector`

## Requirements
- R1: While `rst_n` is low, the registered outputs hold `trap_valid`=0, `trap_type`=0 and `trap_prio`=0, even when requests are pending.
- R2: When no request is pending, `trap_valid`=0, `trap_type`=0 and `trap_prio`=0.
- R3: Bit k of `fault_req` is a fixed fault whose code/priority is entry k of this list, counting from 0: 0x001/0, 0x002/1, 0x003/1, 0x004/1, 0x005/1, 0x008/5, 0x009/2, 0x00A/3, 0x010/7, 0x011/6, 0x012/6, 0x013/6, 0x020/8, 0x021/11, 0x022/11, 0x023/14, 0x024/10, 0x028/15, 0x029/4, 0x030/12, 0x031/12, 0x032/12, 0x033/12, 0x034/10, 0x035/10, 0x036/10, 0x037/11, 0x038/10, 0x039/10, 0x040/2.
- R4: Among pending requests, the one with the numerically lowest priority value is selected, whatever its code.
- R5: When several pending requests share the lowest priority value, the one with the lowest trap-type code is selected.
- R6: A nonzero `irq_level` L (1 to 15) requests code 0x040+L with priority 32-L. `irq_level`=0 requests nothing.
- R7: The window classes request code base+4*idx at priority 9. The bases are 0x080 for spill-normal, 0x0A0 for spill-other, 0x0C0 for fill-normal and 0x0E0 for fill-other, and idx is the 3-bit class index.
- R8: A software trap requests code 0x100+`swtrap_num` (7 bits) at priority 16.
- R9: A pending interrupt is selected only when no fixed fault, window class or software trap is pending.
- R10: With `REG_OUT`=1 the outputs show the arbitration of the inputs sampled at the previous rising clock edge and hold until the next edge. With `REG_OUT`=0 they follow the current inputs.
- R11: `trap_valid` is high exactly when at least one request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| fault_req | input | 30 | Fixed fault request lines, bit order as in R3 |
| irq_level | input | 4 | Pending interrupt level, 0 means none |
| spill_norm_req | input | 1 | Spill-normal request |
| spill_norm_idx | input | 3 | Spill-normal index |
| spill_oth_req | input | 1 | Spill-other request |
| spill_oth_idx | input | 3 | Spill-other index |
| fill_norm_req | input | 1 | Fill-normal request |
| fill_norm_idx | input | 3 | Fill-normal index |
| fill_oth_req | input | 1 | Fill-other request |
| fill_oth_idx | input | 3 | Fill-other index |
| swtrap_req | input | 1 | Software trap request |
| swtrap_num | input | 7 | Software trap number |
| trap_valid | output | 1 | A request won arbitration |
| trap_type | output | 9 | Code of the winner |
| trap_prio | output | 5 | Priority value of the winner |

## Verification
The hardest case to reach from the ports is a tie: two or more requests pending at once that share the lowest priority value. The arbiter must then fall back to comparing codes. Independent random vectors rarely produce such a tie.

The stimulus builds its fault vectors by ANDing several random words, which keeps the number of set bits small. It also raises the window classes and the interrupt together with the faults. Directed vectors add specific collisions:
- two priority-2 faults whose codes are far apart;
- two data faults at priority 12;
- a spill-normal class against a fill-other class, both at priority 9;
- the highest interrupt level against a software trap.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;

   localparam int TT_W      = 9;
   localparam int PRIO_W    = 5;
   localparam int NUM_FIXED = 30;
   localparam int NUM_ENUM  = 6;
   localparam int NUM_CAND  = NUM_FIXED + NUM_ENUM;

   typedef struct packed {
      logic              vld;
      logic [PRIO_W-1:0] prio;
      logic [TT_W-1:0]   tt;
   } trap_cand_t;

   // Fixed faults sorted by ascending code; index = request bit.
   function automatic logic [TT_W-1:0] fixed_code(input int k);
      logic [TT_W-1:0] c;
      case (k)
         0:  c = 9'h001;  1:  c = 9'h002;  2:  c = 9'h003;  3:  c = 9'h004;
         4:  c = 9'h005;  5:  c = 9'h008;  6:  c = 9'h009;  7:  c = 9'h00A;
         8:  c = 9'h010;  9:  c = 9'h011;  10: c = 9'h012;  11: c = 9'h013;
         12: c = 9'h020;  13: c = 9'h021;  14: c = 9'h022;  15: c = 9'h023;
         16: c = 9'h024;  17: c = 9'h028;  18: c = 9'h029;  19: c = 9'h030;
         20: c = 9'h031;  21: c = 9'h032;  22: c = 9'h033;  23: c = 9'h034;
         24: c = 9'h035;  25: c = 9'h036;  26: c = 9'h037;  27: c = 9'h038;
         28: c = 9'h039;  29: c = 9'h040;
         default: c = '0;
      endcase
      return c;
   endfunction

   function automatic logic [PRIO_W-1:0] fixed_prio(input int k);
      logic [PRIO_W-1:0] p;
      case (k)
         0:  p = 5'd0;   1:  p = 5'd1;   2:  p = 5'd1;   3:  p = 5'd1;
         4:  p = 5'd1;   5:  p = 5'd5;   6:  p = 5'd2;   7:  p = 5'd3;
         8:  p = 5'd7;   9:  p = 5'd6;   10: p = 5'd6;   11: p = 5'd6;
         12: p = 5'd8;   13: p = 5'd11;  14: p = 5'd11;  15: p = 5'd14;
         16: p = 5'd10;  17: p = 5'd15;  18: p = 5'd4;   19: p = 5'd12;
         20: p = 5'd12;  21: p = 5'd12;  22: p = 5'd12;  23: p = 5'd10;
         24: p = 5'd10;  25: p = 5'd10;  26: p = 5'd11;  27: p = 5'd10;
         28: p = 5'd10;  29: p = 5'd2;
         default: p = '1;
      endcase
      return p;
   endfunction

   // True when a must be chosen over b: valid and strictly smaller {prio,code}.
   function automatic logic cand_beats(input trap_cand_t a, input trap_cand_t b);
      return a.vld && (!b.vld || ({a.prio, a.tt} < {b.prio, b.tt}));
   endfunction

endpackage

// File: rtl/trap_enum_encode.sv
module trap_enum_encode
   import trap_sel_pkg::*;
#(
   parameter int LVL_W = 4,
   parameter int WIN_W = 3,
   parameter int SWT_W = 7
) (
   input  logic [LVL_W-1:0] irq_level,
   input  logic [3:0]       win_req,
   input  logic [WIN_W-1:0] win_idx [4],
   input  logic             swtrap_req,
   input  logic [SWT_W-1:0] swtrap_num,
   output trap_cand_t       cand [NUM_ENUM]
);

   localparam logic [TT_W-1:0]   IRQ_BASE  = 9'h040;
   localparam logic [TT_W-1:0]   WIN_BASE  = 9'h080;
   localparam logic [TT_W-1:0]   WIN_STEP  = 9'h020;
   localparam logic [TT_W-1:0]   SWT_BASE  = 9'h100;
   localparam logic [PRIO_W-1:0] WIN_PRIO  = 5'd9;
   localparam logic [PRIO_W-1:0] SWT_PRIO  = 5'd16;
   localparam int                IRQ_TOP   = 32;

   generate
      if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
         $error("LVL_W must be 1..4 so interrupts rank below software traps");
      end
      if (WIN_W < 1 || WIN_W > 3) begin : g_bad_win
         $error("WIN_W must be 1..3 so index*4 stays inside a 32-code class");
      end
      if (SWT_W < 1 || SWT_W > 8) begin : g_bad_swt
         $error("SWT_W must be 1..8 to fit the 9-bit code");
      end
   endgenerate

   // Interrupt: level 0 means nothing pending.
   logic [TT_W-1:0]   irq_tt;
   logic [PRIO_W-1:0] irq_prio;
   always_comb begin
      irq_tt   = IRQ_BASE + TT_W'(irq_level);
      irq_prio = PRIO_W'(IRQ_TOP - int'(irq_level));
   end
   assign cand[0] = '{vld: (irq_level != '0), prio: irq_prio, tt: irq_tt};

   // Four window classes, 32 codes apart, index at bits [4:2].
   for (genvar w = 0; w < 4; w++) begin : g_win
      localparam logic [TT_W-1:0] BASE = WIN_BASE + TT_W'(w) * WIN_STEP;
      assign cand[1+w] = '{vld:  win_req[w],
                           prio: WIN_PRIO,
                           tt:   BASE | (TT_W'(win_idx[w]) << 2)};
   end

   assign cand[5] = '{vld: swtrap_req, prio: SWT_PRIO, tt: SWT_BASE + TT_W'(swtrap_num)};

endmodule

// File: rtl/trap_prio_tree.sv
module trap_prio_tree
   import trap_sel_pkg::*;
#(
   parameter int N = NUM_CAND
) (
   input  trap_cand_t leaf [N],
   output trap_cand_t best
);

   localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
   localparam int P      = 1 << LEVELS;

   generate
      if (N < 1) begin : g_bad_n
         $error("trap_prio_tree needs at least one leaf");
      end
   endgenerate

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int CNT = P >> l;
      trap_cand_t node [CNT];
      if (l == 0) begin : g_leaf
         for (genvar j = 0; j < CNT; j++) begin : g_j
            if (j < N) begin : g_real
               assign node[j] = leaf[j];
            end else begin : g_pad
               assign node[j] = '0;
            end
         end
      end else begin : g_cmp
         for (genvar j = 0; j < CNT; j++) begin : g_j
            // Left child has the lower leaf index; right must be strictly better.
            assign node[j] = cand_beats(g_lvl[l-1].node[2*j+1], g_lvl[l-1].node[2*j])
                             ? g_lvl[l-1].node[2*j+1] : g_lvl[l-1].node[2*j];
         end
      end
   end

   assign best = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage
   import trap_sel_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  trap_cand_t        win,
   output logic              valid,
   output logic [TT_W-1:0]   tt,
   output logic [PRIO_W-1:0] prio
);

   trap_cand_t clean;
   assign clean = win.vld ? win : '0;

   generate
      if (REG_OUT) begin : g_reg
         trap_cand_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= clean;
         end
         assign valid = q.vld;
         assign tt    = q.tt;
         assign prio  = q.prio;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign valid = clean.vld;
         assign tt    = clean.tt;
         assign prio  = clean.prio;
      end
   endgenerate

endmodule

// File: rtl/trap_type_selector.sv
module trap_type_selector
   import trap_sel_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [29:0] fault_req,
   input  logic [3:0]  irq_level,
   input  logic        spill_norm_req,
   input  logic [2:0]  spill_norm_idx,
   input  logic        spill_oth_req,
   input  logic [2:0]  spill_oth_idx,
   input  logic        fill_norm_req,
   input  logic [2:0]  fill_norm_idx,
   input  logic        fill_oth_req,
   input  logic [2:0]  fill_oth_idx,
   input  logic        swtrap_req,
   input  logic [6:0]  swtrap_num,
   output logic        trap_valid,
   output logic [8:0]  trap_type,
   output logic [4:0]  trap_prio
);

   generate
      if (NUM_FIXED != 30 || TT_W != 9 || PRIO_W != 5) begin : g_bad_pkg
         $error("package widths do not match the port list");
      end
   endgenerate

   logic [3:0] win_req;
   logic [2:0] win_idx [4];
   assign win_req    = {fill_oth_req, fill_norm_req, spill_oth_req, spill_norm_req};
   assign win_idx[0] = spill_norm_idx;
   assign win_idx[1] = spill_oth_idx;
   assign win_idx[2] = fill_norm_idx;
   assign win_idx[3] = fill_oth_idx;

   trap_cand_t enum_cand [NUM_ENUM];
   trap_cand_t leaf      [NUM_CAND];
   trap_cand_t winner;

   trap_enum_encode #(.LVL_W(4), .WIN_W(3), .SWT_W(7)) u_enum (
      .irq_level  (irq_level),
      .win_req    (win_req),
      .win_idx    (win_idx),
      .swtrap_req (swtrap_req),
      .swtrap_num (swtrap_num),
      .cand       (enum_cand)
   );

   for (genvar k = 0; k < NUM_FIXED; k++) begin : g_fixed
      assign leaf[k] = '{vld: fault_req[k], prio: fixed_prio(k), tt: fixed_code(k)};
   end
   for (genvar e = 0; e < NUM_ENUM; e++) begin : g_enum
      assign leaf[NUM_FIXED+e] = enum_cand[e];
   end

   trap_prio_tree #(.N(NUM_CAND)) u_tree (
      .leaf (leaf),
      .best (winner)
   );

   trap_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .win   (winner),
      .valid (trap_valid),
      .tt    (trap_type),
      .prio  (trap_prio)
   );

endmodule

// File: rtl/trap_type_selector_chk.sv
module trap_type_selector_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [29:0] fault_req,
   input logic [3:0]  irq_level,
   input logic        spill_norm_req,
   input logic        spill_oth_req,
   input logic        fill_norm_req,
   input logic        fill_oth_req,
   input logic        swtrap_req,
   input logic        trap_valid,
   input logic [8:0]  trap_type,
   input logic [4:0]  trap_prio
);

   logic sync_any, any_req;
   assign sync_any = (fault_req != '0) || spill_norm_req || spill_oth_req ||
                     fill_norm_req || fill_oth_req || swtrap_req;
   assign any_req  = sync_any || (irq_level != '0);

   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |-> (trap_type == 9'h000 && trap_prio == 5'd0));

   p_irq_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_type[8:4] == 5'h04 && trap_type[3:0] != 4'h0)
      |-> (trap_prio == 5'(6'd32 - {2'b00, trap_type[3:0]})));

   p_win_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_type[8:7] == 2'b01) |-> (trap_prio == 5'd9 && trap_type[1:0] == 2'b00));

   p_swtrap_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_type[8]) |-> (trap_prio == 5'd16));

   generate
      if (REG_OUT) begin : g_reg
         p_valid_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (trap_valid == $past(any_req)));
         p_irq_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && trap_valid && trap_prio > 5'd16) |-> !$past(sync_any));
      end else begin : g_comb
         p_valid_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid == any_req);
         p_irq_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (trap_valid && trap_prio > 5'd16) |-> !sync_any);
      end
   endgenerate

endmodule

bind trap_type_selector trap_type_selector_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fault_req      (fault_req),
   .irq_level      (irq_level),
   .spill_norm_req (spill_norm_req),
   .spill_oth_req  (spill_oth_req),
   .fill_norm_req  (fill_norm_req),
   .fill_oth_req   (fill_oth_req),
   .swtrap_req     (swtrap_req),
   .trap_valid     (trap_valid),
   .trap_type      (trap_type),
   .trap_prio      (trap_prio)
);

// File: tb/trap_type_selector_tb.sv
module trap_type_selector_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic        rst_n;
   logic [29:0] fault_req;
   logic [3:0]  irq_level;
   logic        sn_req, so_req, fn_req, fo_req, swt_req;
   logic [2:0]  sn_idx, so_idx, fn_idx, fo_idx;
   logic [6:0]  swt_num;

   logic       r_valid, c_valid;
   logic [8:0] r_type,  c_type;
   logic [4:0] r_prio,  c_prio;

   int checks = 0;
   int errors = 0;
   logic [14:0] prev_exp;

   trap_type_selector #(.REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .irq_level(irq_level),
      .spill_norm_req(sn_req), .spill_norm_idx(sn_idx),
      .spill_oth_req(so_req),  .spill_oth_idx(so_idx),
      .fill_norm_req(fn_req),  .fill_norm_idx(fn_idx),
      .fill_oth_req(fo_req),   .fill_oth_idx(fo_idx),
      .swtrap_req(swt_req), .swtrap_num(swt_num),
      .trap_valid(r_valid), .trap_type(r_type), .trap_prio(r_prio)
   );

   trap_type_selector #(.REG_OUT(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .irq_level(irq_level),
      .spill_norm_req(sn_req), .spill_norm_idx(sn_idx),
      .spill_oth_req(so_req),  .spill_oth_idx(so_idx),
      .fill_norm_req(fn_req),  .fill_norm_idx(fn_idx),
      .fill_oth_req(fo_req),   .fill_oth_idx(fo_idx),
      .swtrap_req(swt_req), .swtrap_num(swt_num),
      .trap_valid(c_valid), .trap_type(c_type), .trap_prio(c_prio)
   );

   // Code and priority of fault bit k, per R3.
   function automatic logic [13:0] tb_entry(input int k);
      case (k)
         0:  return {5'd0,  9'h001};  1:  return {5'd1,  9'h002};
         2:  return {5'd1,  9'h003};  3:  return {5'd1,  9'h004};
         4:  return {5'd1,  9'h005};  5:  return {5'd5,  9'h008};
         6:  return {5'd2,  9'h009};  7:  return {5'd3,  9'h00A};
         8:  return {5'd7,  9'h010};  9:  return {5'd6,  9'h011};
         10: return {5'd6,  9'h012};  11: return {5'd6,  9'h013};
         12: return {5'd8,  9'h020};  13: return {5'd11, 9'h021};
         14: return {5'd11, 9'h022};  15: return {5'd14, 9'h023};
         16: return {5'd10, 9'h024};  17: return {5'd15, 9'h028};
         18: return {5'd4,  9'h029};  19: return {5'd12, 9'h030};
         20: return {5'd12, 9'h031};  21: return {5'd12, 9'h032};
         22: return {5'd12, 9'h033};  23: return {5'd10, 9'h034};
         24: return {5'd10, 9'h035};  25: return {5'd10, 9'h036};
         26: return {5'd11, 9'h037};  27: return {5'd10, 9'h038};
         28: return {5'd10, 9'h039};  29: return {5'd2,  9'h040};
         default: return 14'h3FFF;
      endcase
   endfunction

   // Expected {valid, prio, code}, per R2..R9.
   function automatic logic [14:0] ref_pick();
      logic        cv [36];
      logic [13:0] ck [36];
      logic        bv = 1'b0;
      logic [13:0] bk = '0;
      for (int k = 0; k < 30; k++) begin
         cv[k] = fault_req[k];
         ck[k] = tb_entry(k);
      end
      cv[30] = (irq_level != 0);
      ck[30] = {5'(6'd32 - {2'b00, irq_level}), 9'h040 + {5'd0, irq_level}};
      cv[31] = sn_req;  ck[31] = {5'd9, 9'h080 + {4'd0, sn_idx, 2'b00}};
      cv[32] = so_req;  ck[32] = {5'd9, 9'h0A0 + {4'd0, so_idx, 2'b00}};
      cv[33] = fn_req;  ck[33] = {5'd9, 9'h0C0 + {4'd0, fn_idx, 2'b00}};
      cv[34] = fo_req;  ck[34] = {5'd9, 9'h0E0 + {4'd0, fo_idx, 2'b00}};
      cv[35] = swt_req; ck[35] = {5'd16, 9'h100 + {2'd0, swt_num}};
      for (int k = 0; k < 36; k++) begin
         if (cv[k] && (!bv || ck[k] < bk)) begin
            bv = 1'b1;
            bk = ck[k];
         end
      end
      return {bv, bk};
   endfunction

   task automatic chk(input string tag, input string who,
                      input logic [14:0] act, input logic [14:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got valid=%0b prio=%0d type=0x%03h, expected valid=%0b prio=%0d type=0x%03h",
                  tag, who, act[14], act[13:9], act[8:0], exp[14], exp[13:9], exp[8:0]);
      end
   endtask

   task automatic clear_in();
      fault_req = '0; irq_level = '0;
      sn_req = 0; so_req = 0; fn_req = 0; fo_req = 0; swt_req = 0;
      sn_idx = '0; so_idx = '0; fn_idx = '0; fo_idx = '0; swt_num = '0;
   endtask

   // Called just after a falling edge with inputs already set.
   task automatic step(input string tag);
      logic [14:0] exp;
      #1;
      exp = ref_pick();
      chk(tag, "comb", {c_valid, c_prio, c_type}, exp);
      chk("R10", "reg-hold", {r_valid, r_prio, r_type}, prev_exp);
      @(posedge clk); #1;
      chk(tag, "reg", {r_valid, r_prio, r_type}, exp);
      prev_exp = exp;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_7A11));
      rst_n = 1'b0;
      clear_in();
      fault_req = 30'h1;
      repeat (2) @(posedge clk);
      #1;
      chk("R1", "reg-in-reset", {r_valid, r_prio, r_type}, 15'h0);
      @(negedge clk);
      clear_in();
      rst_n = 1'b1;
      prev_exp = '0;
      @(negedge clk);

      step("R2");                                    // nothing pending
      irq_level = 4'd0; step("R6");                  // level 0 requests nothing

      for (int k = 0; k < 30; k++) begin             // every fixed fault alone
         clear_in(); fault_req[k] = 1'b1; step("R3");
      end

      clear_in(); fault_req[17] = 1; fault_req[18] = 1; step("R4");   // 0x029 over 0x028
      clear_in(); fault_req[0] = 1; fault_req[29] = 1; swt_req = 1; step("R4");
      clear_in(); fault_req[6] = 1; fault_req[29] = 1; step("R5");    // 0x009 vs 0x040
      clear_in(); fault_req[22] = 1; fault_req[19] = 1; step("R5");   // 0x030
      clear_in(); fo_req = 1; sn_req = 1; sn_idx = 3'd7; step("R5");  // 0x09C

      clear_in(); irq_level = 4'd1;  step("R6");
      clear_in(); irq_level = 4'd15; step("R6");
      clear_in(); sn_req = 1; sn_idx = 3'd5; step("R7");
      clear_in(); so_req = 1; so_idx = 3'd7; step("R7");
      clear_in(); fn_req = 1; fn_idx = 3'd0; step("R7");
      clear_in(); fo_req = 1; fo_idx = 3'd3; step("R7");
      clear_in(); swt_req = 1; swt_num = 7'd0;   step("R8");
      clear_in(); swt_req = 1; swt_num = 7'd127; step("R8");
      clear_in(); irq_level = 4'd15; swt_req = 1; swt_num = 7'd9; step("R9");
      clear_in(); irq_level = 4'd15; fault_req[15] = 1; step("R9");
      clear_in(); fault_req[3] = 1; step("R11");
      clear_in(); step("R11");

      for (int i = 0; i < 600; i++) begin
         clear_in();
         fault_req = 30'($urandom & $urandom & $urandom & $urandom);
         if ($urandom_range(0, 2) == 0) fault_req = '0;
         irq_level = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom);
         sn_req = ($urandom_range(0, 3) == 0); sn_idx = 3'($urandom);
         so_req = ($urandom_range(0, 3) == 0); so_idx = 3'($urandom);
         fn_req = ($urandom_range(0, 3) == 0); fn_idx = 3'($urandom);
         fo_req = ($urandom_range(0, 3) == 0); fo_idx = 3'($urandom);
         swt_req = ($urandom_range(0, 4) == 0); swt_num = 7'($urandom);
         step("R4/R5 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule